// File: doc/BRIEF.md
# Multi-format video output formatter

This block places processed pixel data onto a 16-bit parallel video output bus, with an 8-bit extension byte for the 24-bit RGB format. A 3-bit format code selects one of five layouts: YUV 4:2:2, YUV 4:1:1, RGB 5-6-5, RGB 8-8-8, or a raw pass-through of two ADC bytes. The block also produces a clock qualifier that marks each beat on the bus, a line reference pulse that frames the active samples of a line, and a pad output-enable.

A rising edge on the line-active input starts a line. The block samples the format code at that edge only, aligns the qualifier phase to it, and raises the line reference for a fixed count of beats. That count is the same on every line, including lines in vertical blanking. The half-rate formats put a beat on every second clock. RGB 8-8-8 puts a beat on every clock. The source holds its sample inputs steady across the beats that use them.

Top module: `vid_out_fmt`

## Requirements
- R1: While rst_ni is low, vpo_o, ext_o, cref_o and href_o are all 0.
- R2: In every format except code 3, cref_o is high for one cycle and then low for one cycle, with the high cycle starting on the clock edge that samples a line start. In format code 3 (RGB 8-8-8), cref_o is high on every cycle.
- R3: href_o rises on the clock edge that first samples line_act_i high after a low sample. It stays high for LINE_LEN beats, which is 2*LINE_LEN cycles in half-rate formats and LINE_LEN cycles in format 3. It does not depend on the sample inputs, and a new line start restarts it.
- R4: In format 0 (YUV 4:2:2), vpo_o[15:8] carries y_i. vpo_o[7:0] carries cb_i on even beats and cr_i on odd beats, and beat 0 of a line carries Cb.
- R5: In format 1 (YUV 4:1:1), vpo_o[15:8] carries y_i and vpo_o[3:0] is 0. On beat k of a line, with j = k mod 4, vpo_o[7:6] carries cb_i[7-2j:6-2j] and vpo_o[5:4] carries cr_i[7-2j:6-2j].
- R6: In format 2 (RGB 5-6-5), vpo_o carries r_i[7:3] in bits 15:11, g_i[7:2] in bits 10:5 and b_i[7:3] in bits 4:0.
- R7: In format 3, vpo_o carries {r_i, g_i} and ext_o carries b_i. In every other format ext_o is 0.
- R8: In format 4 (raw bypass), vpo_o is {ad1_i, ad2_i}, loaded on every beat whether or not href_o is high.
- R9: In formats 0 to 3, vpo_o is 0 whenever href_o is low. Format codes 5 to 7 always give 0.
- R10: fmt_i is sampled only on the line-start edge. A change in the middle of a line has no effect until the next line.
- R11: vpo_oe_o is low, combinationally, exactly when both fast_hiz_i and oe_gate_i are high. Otherwise it is high.
- R12: vpo_o and ext_o change only on the clock edge that begins a beat (a cycle with cref_o high). They hold their value through the cycle between half-rate beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_act_i | input | 1 | Line active; a rising edge starts a line |
| fmt_i | input | 3 | Output format code |
| oe_gate_i | input | 1 | Allows fast_hiz_i to float the bus |
| fast_hiz_i | input | 1 | Fast high-impedance request |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Cb sample |
| cr_i | input | 8 | Cr sample |
| r_i | input | 8 | Red component |
| g_i | input | 8 | Green component |
| b_i | input | 8 | Blue component |
| ad1_i | input | 8 | Raw ADC channel 1 byte |
| ad2_i | input | 8 | Raw ADC channel 2 byte |
| vpo_o | output | 16 | Output bus data |
| ext_o | output | 8 | Extension byte (blue in RGB 8-8-8) |
| vpo_oe_o | output | 1 | Pad output enable, high drives the bus |
| cref_o | output | 1 | Clock qualifier |
| href_o | output | 1 | Line reference |

## Verification
A wrong qualifier phase shows on cref_o in the cycle right after the line-start edge. It also shifts the data of every later beat by one clock. A beat counter that is off shows as Cb and Cr swapped on the second beat, as the wrong 4:1:1 bit pair, or as a line reference that is the wrong length when it falls. A format register that latches at the wrong time shows at the next beat after a mid-line change. A bus that loads on idle cycles shows one cycle after a sample input changes between beats.

// File: rtl/vof_pkg.sv
package vof_pkg;
  localparam int unsigned PIX_W = 8;
  localparam int unsigned BUS_W = 2 * PIX_W;

  localparam logic [2:0] FMT_YUV422 = 3'd0;
  localparam logic [2:0] FMT_YUV411 = 3'd1;
  localparam logic [2:0] FMT_RGB565 = 3'd2;
  localparam logic [2:0] FMT_RGB888 = 3'd3;
  localparam logic [2:0] FMT_RAW    = 3'd4;

  function automatic logic fmt_full_rate(input logic [2:0] f);
    return f == FMT_RGB888;
  endfunction
endpackage

// File: rtl/vof_timing.sv
module vof_timing
  import vof_pkg::*;
#(
  parameter int unsigned LINE_LEN = 720,
  localparam int unsigned CW = $clog2(LINE_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_act_i,
  input  logic [2:0]    fmt_i,
  output logic [2:0]    fmt_n_o,
  output logic [2:0]    fmt_q_o,
  output logic [1:0]    idx_n_o,
  output logic          load_o,
  output logic          active_n_o,
  output logic          cref_o,
  output logic          href_o
);
  localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

  logic          act_q, ph_q, href_q;
  logic [2:0]    fmt_q;
  logic [CW-1:0] cnt_q;
  logic          start, ph_n, href_n;
  logic [2:0]    fmt_n;
  logic [CW-1:0] cnt_n;

  always_comb begin
    start  = line_act_i & ~act_q;
    fmt_n  = start ? fmt_i : fmt_q;
    ph_n   = start | fmt_full_rate(fmt_n) | ~ph_q;
    if (start)               cnt_n = '0;
    else if (ph_n && href_q) cnt_n = cnt_q + 1'b1;
    else                     cnt_n = cnt_q;
    if (start)                                 href_n = 1'b1;
    else if (href_q && ph_n && cnt_q == LAST)  href_n = 1'b0;
    else                                       href_n = href_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      href_q <= 1'b0;
      fmt_q  <= FMT_YUV422;
      cnt_q  <= '0;
    end else begin
      act_q  <= line_act_i;
      ph_q   <= ph_n;
      href_q <= href_n;
      fmt_q  <= fmt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign fmt_n_o    = fmt_n;
  assign fmt_q_o    = fmt_q;
  assign idx_n_o    = cnt_n[1:0];
  assign load_o     = ph_n;
  assign active_n_o = href_n;
  assign cref_o     = ph_q;
  assign href_o     = href_q;

  p_cref_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q && !fmt_full_rate(fmt_q) && !start) |=> !ph_q);
  p_cref_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_full_rate(fmt_q) && !start) |=> ph_q);
  p_line_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (href_q && ph_q && cnt_q == '0));
  p_href_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    href_q |-> cnt_q < CW'(LINE_LEN));
  p_fmt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable(fmt_q));
endmodule

// File: rtl/vof_pack.sv
module vof_pack
  import vof_pkg::*;
(
  input  logic [2:0]       fmt_i,
  input  logic [1:0]       idx_i,
  input  logic             active_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [PIX_W-1:0] ad1_i,
  input  logic [PIX_W-1:0] ad2_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [PIX_W-1:0] ext_o
);
  logic [PIX_W-1:0] cb_sh, cr_sh;

  // 4:1:1 sends two bits of each chroma per beat, msb pair first
  always_comb begin
    cb_sh = cb_i << {idx_i, 1'b0};
    cr_sh = cr_i << {idx_i, 1'b0};
  end

  always_comb begin
    bus_o = '0;
    ext_o = '0;
    unique case (fmt_i)
      FMT_YUV422: if (active_i) bus_o = {y_i, idx_i[0] ? cr_i : cb_i};
      FMT_YUV411: if (active_i) bus_o = {y_i, cb_sh[7:6], cr_sh[7:6], 4'b0000};
      FMT_RGB565: if (active_i) bus_o = {r_i[7:3], g_i[7:2], b_i[7:3]};
      FMT_RGB888: if (active_i) begin
        bus_o = {r_i, g_i};
        ext_o = b_i;
      end
      FMT_RAW:    bus_o = {ad1_i, ad2_i};
      default:    bus_o = '0;
    endcase
  end
endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
  import vof_pkg::*;
#(
  parameter int unsigned LINE_LEN = 720
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_act_i,
  input  logic [2:0]  fmt_i,
  input  logic        oe_gate_i,
  input  logic        fast_hiz_i,
  input  logic [7:0]  y_i,
  input  logic [7:0]  cb_i,
  input  logic [7:0]  cr_i,
  input  logic [7:0]  r_i,
  input  logic [7:0]  g_i,
  input  logic [7:0]  b_i,
  input  logic [7:0]  ad1_i,
  input  logic [7:0]  ad2_i,
  output logic [15:0] vpo_o,
  output logic [7:0]  ext_o,
  output logic        vpo_oe_o,
  output logic        cref_o,
  output logic        href_o
);
  logic [2:0]       fmt_n, fmt_q;
  logic [1:0]       idx_n;
  logic             load, active_n;
  logic [BUS_W-1:0] bus_d, vpo_q;
  logic [PIX_W-1:0] ext_d, ext_q;

  vof_timing #(.LINE_LEN(LINE_LEN)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_act_i (line_act_i),
    .fmt_i      (fmt_i),
    .fmt_n_o    (fmt_n),
    .fmt_q_o    (fmt_q),
    .idx_n_o    (idx_n),
    .load_o     (load),
    .active_n_o (active_n),
    .cref_o     (cref_o),
    .href_o     (href_o)
  );

  vof_pack u_pack (
    .fmt_i    (fmt_n),
    .idx_i    (idx_n),
    .active_i (active_n),
    .y_i      (y_i),
    .cb_i     (cb_i),
    .cr_i     (cr_i),
    .r_i      (r_i),
    .g_i      (g_i),
    .b_i      (b_i),
    .ad1_i    (ad1_i),
    .ad2_i    (ad2_i),
    .bus_o    (bus_d),
    .ext_o    (ext_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpo_q <= '0;
      ext_q <= '0;
    end else if (load) begin
      vpo_q <= bus_d;
      ext_q <= ext_d;
    end
  end

  assign vpo_o    = vpo_q;
  assign ext_o    = ext_q;
  assign vpo_oe_o = ~(fast_hiz_i & oe_gate_i);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(vpo_q) && $stable(ext_q)) |-> cref_o);
  p_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!href_o && fmt_q <= FMT_RGB888) |-> (vpo_q == '0 && ext_q == '0));
  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q > FMT_RAW) |-> vpo_q == '0);
  p_ext_only_888_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q != FMT_RGB888) |-> ext_q == '0);
endmodule

// File: tb/sim_vid_out_fmt.sv
module sim_vid_out_fmt;
  localparam int PERIOD = 10;
  localparam int LL = 8;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [7:0]  y, cb, cr, r, g, b, a1, a2;
    logic [15:0] e0, e2;
    logic [7:0]  ex;
    logic        full;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 8'h5A, 8'h11, 8'hEE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h5A11, 16'h5AEE, 8'h00, 1'b0},
    '{3'd1, 8'h33, 8'hB6, 8'h4D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h3390, 16'h33C0, 8'h00, 1'b0},
    '{3'd2, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h3C, 8'h96, 8'h00, 8'h00, 16'hA1F2, 16'hA1F2, 8'h00, 1'b0},
    '{3'd3, 8'h00, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 16'h1234, 16'h1234, 8'h56, 1'b1},
    '{3'd4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC3, 8'h7E, 16'hC37E, 16'hC37E, 8'h00, 1'b0},
    '{3'd5, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 16'h0000, 16'h0000, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_act = 1'b0, oe_gate = 1'b0, fast_hiz = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [7:0] y = 0, cb = 0, cr = 0, r = 0, g = 0, b = 0, ad1 = 0, ad2 = 0;
  logic [15:0] vpo;
  logic [7:0] ext;
  logic vpo_oe, cref, href;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  vid_out_fmt #(.LINE_LEN(LL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_act_i(line_act), .fmt_i(fmt),
    .oe_gate_i(oe_gate), .fast_hiz_i(fast_hiz),
    .y_i(y), .cb_i(cb), .cr_i(cr), .r_i(r), .g_i(g), .b_i(b),
    .ad1_i(ad1), .ad2_i(ad2),
    .vpo_o(vpo), .ext_o(ext), .vpo_oe_o(vpo_oe), .cref_o(cref), .href_o(href)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // leaves time at the negedge right after the line-start edge (beat 0)
  task automatic start_line();
    @(negedge clk) line_act = 1'b0;
    @(negedge clk) line_act = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_out(output int n);
    n = 0;
    for (int i = 0; i < 100 && href; i++) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len;
    #(PERIOD * 3 + 2);
    chk("R1 vpo", vpo, 0);
    chk("R1 ext", ext, 0);
    chk("R1 cref", cref, 0);
    chk("R1 href", href, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      fmt = VECS[k].fmt; y = VECS[k].y; cb = VECS[k].cb; cr = VECS[k].cr;
      r = VECS[k].r; g = VECS[k].g; b = VECS[k].b; ad1 = VECS[k].a1; ad2 = VECS[k].a2;
      start_line();
      chk("R4-R9 beat0 bus (R4 R5 R6 R7 R8 R9)", vpo, VECS[k].e0);
      chk("R7 ext", ext, VECS[k].ex);
      chk("R2 cref beat0", cref, 1);
      chk("R3 href rise", href, 1);
      @(negedge clk);
      chk("R2 cref second cycle", cref, VECS[k].full);
      @(negedge clk);
      chk("R4 R5 second sample bus", vpo, VECS[k].e2);
    end

    // R3 length, R9 blanking
    fmt = 3'd0; y = 8'h44; cb = 8'h55; cr = 8'h66;
    start_line();
    run_out(len);
    chk("R3 half-rate href length", len, 2 * LL);
    chk("R9 blank after line", vpo, 0);
    fmt = 3'd3;
    start_line();
    run_out(len);
    chk("R3 full-rate href length", len, LL);
    chk("R9 ext blank", ext, 0);

    // R8 bypass while href low
    fmt = 3'd4;
    start_line();
    run_out(len);
    ad1 = 8'hA1; ad2 = 8'hB2;
    @(negedge clk); @(negedge clk);
    chk("R8 bypass outside line", vpo, 16'hA1B2);
    chk("R3 href low", href, 0);

    // R10 fmt change mid-line, R12 hold between beats
    fmt = 3'd0; y = 8'h10; cb = 8'h20; cr = 8'h30;
    start_line();
    chk("R4 cb first", vpo, 16'h1020);
    fmt = 3'd2;
    @(negedge clk); @(negedge clk);
    chk("R10 mid-line fmt ignored", vpo, 16'h1030);
    y = 8'h77;
    @(negedge clk);
    chk("R12 hold between beats", vpo, 16'h1030);
    @(negedge clk);
    chk("R12 load on beat", vpo, 16'h7720);

    // R11 output enable
    oe_gate = 1'b0; fast_hiz = 1'b1; #1;
    chk("R11 gate off", vpo_oe, 1);
    oe_gate = 1'b1; fast_hiz = 1'b0; #1;
    chk("R11 fast low", vpo_oe, 1);
    fast_hiz = 1'b1; #1;
    chk("R11 float", vpo_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule